// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block resolves read-after-write hazards in a five-stage in-order integer pipeline. Because instructions issue and execute in program order, only true data dependences are handled. No logic exists for write-after-read or write-after-write cases. The block takes decoded register numbers, source-use flags and write-enable flags from the ID/EX, EX/MEM and MEM/WB latches. For each consumer operand it returns a multiplexer select: the ALU operands, the branch-condition operand and the store data entering memory. The register file, ALU, fetch and branch target logic sit outside the block.

Two operands of one instruction are resolved independently, so each may come from a different producer. When both later stages write the same register, the younger producer in EX/MEM wins. A load in EX/MEM cannot supply its data yet. If a source of the ID/EX instruction matches that load, the block raises a single-cycle stall so that a bubble can be inserted, and the value is then picked up from MEM/WB.

The stall control is a two-state machine. FLOW is the normal state: stall follows the load-use hazard, and a hazard moves the machine to HOLD (transition FLOW→HOLD). HOLD is the bubble cycle: stall is forced low, and the machine always returns to FLOW (transition HOLD→FLOW). Reset places the machine in FLOW.

Top module: `fwd_unit`

## Requirements
- R1: Every select uses the encoding 2'b00 = register file, 2'b01 = MEM/WB result, 2'b10 = EX/MEM result, and never takes the value 2'b11.
- R2: When EX/MEM holds a non-load instruction with write enable set, and its destination equals a used, nonzero ID/EX source, that operand's select is 2'b10.
- R3: When the EX/MEM case does not apply, and MEM/WB has write enable set with a destination equal to a used, nonzero source, the select is 2'b01.
- R4: When EX/MEM and MEM/WB both qualify for the same source, the select is 2'b10, so the younger producer wins.
- R5: Register 0 is never forwarded. A producer with its write enable clear never matches. A source whose use flag is clear selects 2'b00.
- R6: Operand A (rs) and operand B (rt) are resolved independently. One instruction may take A from one stage and B from the other.
- R7: When the ID/EX instruction is a branch, the branch select equals the rs operand's select. Otherwise the branch select is 2'b00.
- R8: When EX/MEM is a store whose data register is nonzero, and MEM/WB writes that register with write enable set, the store-data select is 2'b01. In every other case it is 2'b00.
- R9: When EX/MEM is a load with write enable set, and its nonzero destination matches a used ID/EX source, stall is high in state FLOW. That operand never selects 2'b10 from the load.
- R10: Stall is never high in two consecutive cycles. After a stall cycle (state HOLD), stall is low even if the hazard inputs stay the same. A persistent hazard gives the pattern high, low, high, low.
- R11: Reset returns the machine to FLOW, so a hazard present right after reset raises stall at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idex_rs | input | REG_W | First source register of the ID/EX instruction |
| idex_rt | input | REG_W | Second source register of the ID/EX instruction |
| idex_rs_used | input | 1 | First source is read |
| idex_rt_used | input | 1 | Second source is read |
| idex_branch | input | 1 | ID/EX instruction is a conditional branch testing rs |
| exmem_rd | input | REG_W | Destination register in EX/MEM |
| exmem_wen | input | 1 | EX/MEM writes a register |
| exmem_load | input | 1 | EX/MEM instruction is a load |
| exmem_store | input | 1 | EX/MEM instruction is a store |
| exmem_sd_reg | input | REG_W | Data register of the store in EX/MEM |
| memwb_rd | input | REG_W | Destination register in MEM/WB |
| memwb_wen | input | 1 | MEM/WB writes a register |
| fwd_a | output | 2 | Select for ALU operand A |
| fwd_b | output | 2 | Select for ALU operand B |
| fwd_br | output | 2 | Select for branch-condition operand |
| fwd_sd | output | 2 | Select for store data at EX/MEM |
| stall | output | 1 | Load-use stall, bubble request |

## Verification
The bench sweeps every combination of four register numbers, the write-enable, load and use flags, and the branch flag. The expected stall in each cycle follows from the previous cycle's stall. Several faults would show up in this sweep. A design that ignored register 0 or the write enable would forward spurious values. A design with the priority reversed would pick MEM/WB when both stages match. A design that forwarded from a load in EX/MEM would select 2'b10 where it must stall. A stall machine without HOLD would keep stall high across a persistent hazard, and a reset that left HOLD set would miss the first hazard after reset. A separate sweep covers store data and shows that a non-store or an unwritten register never pulls MEM/WB data.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_WB  = 2'b01,
        SRC_MEM = 2'b10
    } src_sel_e;

    typedef enum logic [0:0] {
        ST_FLOW = 1'b0,
        ST_HOLD = 1'b1
    } stall_st_e;
endpackage

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
    import fwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic             src_used,
    input  logic [REG_W-1:0] exmem_rd,
    input  logic             exmem_wen,
    input  logic             exmem_load,
    input  logic [REG_W-1:0] memwb_rd,
    input  logic             memwb_wen,
    output src_sel_e         sel,
    output logic             load_hit
);
    logic live;
    logic ex_hit;
    logic wb_hit;

    always_comb begin
        live     = src_used && (src != '0);
        ex_hit   = live && exmem_wen && (exmem_rd == src);
        wb_hit   = live && memwb_wen && (memwb_rd == src);
        load_hit = ex_hit && exmem_load;
        if (ex_hit && !exmem_load) begin
            sel = SRC_MEM;
        end else if (wb_hit) begin
            sel = SRC_WB;
        end else begin
            sel = SRC_RF;
        end
    end
endmodule

// File: rtl/fwd_store_sel.sv
module fwd_store_sel
    import fwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             exmem_store,
    input  logic [REG_W-1:0] exmem_sd_reg,
    input  logic [REG_W-1:0] memwb_rd,
    input  logic             memwb_wen,
    output src_sel_e         sel
);
    always_comb begin
        if (exmem_store && memwb_wen && (exmem_sd_reg != '0) &&
            (memwb_rd == exmem_sd_reg)) begin
            sel = SRC_WB;
        end else begin
            sel = SRC_RF;
        end
    end
endmodule

// File: rtl/fwd_stall_fsm.sv
module fwd_stall_fsm
    import fwd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hazard,
    output logic stall
);
    stall_st_e state;
    stall_st_e state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FLOW;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        stall     = 1'b0;
        unique case (state)
            ST_FLOW: begin
                stall     = hazard;
                state_nxt = hazard ? ST_HOLD : ST_FLOW;
            end
            ST_HOLD: begin
                stall     = 1'b0;
                state_nxt = ST_FLOW;
            end
        endcase
    end

    AST_HOLD_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |=> (state == ST_FLOW)); // R10
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] idex_rs,
    input  logic [REG_W-1:0] idex_rt,
    input  logic             idex_rs_used,
    input  logic             idex_rt_used,
    input  logic             idex_branch,
    input  logic [REG_W-1:0] exmem_rd,
    input  logic             exmem_wen,
    input  logic             exmem_load,
    input  logic             exmem_store,
    input  logic [REG_W-1:0] exmem_sd_reg,
    input  logic [REG_W-1:0] memwb_rd,
    input  logic             memwb_wen,
    output logic [1:0]       fwd_a,
    output logic [1:0]       fwd_b,
    output logic [1:0]       fwd_br,
    output logic [1:0]       fwd_sd,
    output logic             stall
);
    localparam int NUM_SRC = 2;

    logic [REG_W-1:0] src_reg  [NUM_SRC];
    logic             src_use  [NUM_SRC];
    src_sel_e         src_sel  [NUM_SRC];
    logic [NUM_SRC-1:0] load_hit;
    src_sel_e         sd_sel;

    always_comb begin
        src_reg[0] = idex_rs;
        src_reg[1] = idex_rt;
        src_use[0] = idex_rs_used;
        src_use[1] = idex_rt_used;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        fwd_operand_sel #(.REG_W(REG_W)) u_sel (
            .src        (src_reg[g]),
            .src_used   (src_use[g]),
            .exmem_rd   (exmem_rd),
            .exmem_wen  (exmem_wen),
            .exmem_load (exmem_load),
            .memwb_rd   (memwb_rd),
            .memwb_wen  (memwb_wen),
            .sel        (src_sel[g]),
            .load_hit   (load_hit[g])
        );
    end

    fwd_store_sel #(.REG_W(REG_W)) u_sd (
        .exmem_store  (exmem_store),
        .exmem_sd_reg (exmem_sd_reg),
        .memwb_rd     (memwb_rd),
        .memwb_wen    (memwb_wen),
        .sel          (sd_sel)
    );

    fwd_stall_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .hazard (|load_hit),
        .stall  (stall)
    );

    always_comb begin
        fwd_a  = src_sel[0];
        fwd_b  = src_sel[1];
        fwd_br = idex_branch ? src_sel[0] : SRC_RF;
        fwd_sd = sd_sel;
    end

    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a != 2'b11) && (fwd_b != 2'b11) && (fwd_br != 2'b11) && (fwd_sd != 2'b11)); // R1
    AST_ZERO_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_rs == '0) |-> (fwd_a == 2'b00)); // R5
    AST_YOUNGER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_rs_used && idex_rs != '0 && exmem_wen && !exmem_load && exmem_rd == idex_rs
         && memwb_wen && memwb_rd == idex_rs) |-> (fwd_a == 2'b10)); // R4
    AST_BR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !idex_branch |-> (fwd_br == 2'b00)); // R7
    AST_SD_NOSTORE: assert property (@(posedge clk) disable iff (!rst_n)
        !exmem_store |-> (fwd_sd == 2'b00)); // R8
    AST_LOAD_NOT_EX: assert property (@(posedge clk) disable iff (!rst_n)
        exmem_load |-> (fwd_a != 2'b10 && fwd_b != 2'b10)); // R9
    AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall); // R10
endmodule

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb;
    localparam int REG_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [REG_W-1:0] idex_rs = '0, idex_rt = '0, exmem_rd = '0, exmem_sd_reg = '0, memwb_rd = '0;
    logic idex_rs_used = 1'b0, idex_rt_used = 1'b0, idex_branch = 1'b0;
    logic exmem_wen = 1'b0, exmem_load = 1'b0, exmem_store = 1'b0, memwb_wen = 1'b0;
    logic [1:0] fwd_a, fwd_b, fwd_br, fwd_sd;
    logic stall;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit prev_stall = 1'b0;

    always #5 clk = ~clk;

    fwd_unit #(.REG_W(REG_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .idex_rs(idex_rs), .idex_rt(idex_rt),
        .idex_rs_used(idex_rs_used), .idex_rt_used(idex_rt_used),
        .idex_branch(idex_branch),
        .exmem_rd(exmem_rd), .exmem_wen(exmem_wen), .exmem_load(exmem_load),
        .exmem_store(exmem_store), .exmem_sd_reg(exmem_sd_reg),
        .memwb_rd(memwb_rd), .memwb_wen(memwb_wen),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .fwd_br(fwd_br), .fwd_sd(fwd_sd),
        .stall(stall)
    );

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_sel(input int src, input bit used);
        if (!used || src == 0) return 2'b00;          // R5
        if (exmem_wen && !exmem_load && exmem_rd == src) return 2'b10; // R2 R4
        if (memwb_wen && memwb_rd == src) return 2'b01; // R3
        return 2'b00;
    endfunction

    function automatic bit exp_hazard();
        return exmem_wen && exmem_load && exmem_rd != 0 &&
               ((idex_rs_used && exmem_rd == idex_rs) || (idex_rt_used && exmem_rd == idex_rt));
    endfunction

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // Reset state, R11
        repeat (2) @(negedge clk);
        #1;
        check("R11 reset stall", {1'b0, stall}, 2'b00);
        check("R1 reset fwd_a", fwd_a, 2'b00);
        @(negedge clk);
        rst_n = 1'b1;

        // Main sweep: R1..R7, R9, R10
        for (int rs = 0; rs < 4; rs++)
        for (int rt = 0; rt < 4; rt++)
        for (int er = 0; er < 4; er++)
        for (int wr = 0; wr < 4; wr++)
        for (int fl = 0; fl < 64; fl++) begin
            @(negedge clk);
            idex_rs = REG_W'(rs); idex_rt = REG_W'(rt);
            exmem_rd = REG_W'(er); memwb_rd = REG_W'(wr);
            exmem_wen = fl[0]; exmem_load = fl[1]; memwb_wen = fl[2];
            idex_rs_used = fl[3]; idex_rt_used = fl[4]; idex_branch = fl[5];
            exmem_store = 1'b0; exmem_sd_reg = '0;
            #1;
            begin
                logic [1:0] ea, eb;
                bit es;
                ea = exp_sel(rs, fl[3]);
                eb = exp_sel(rt, fl[4]);
                es = exp_hazard() && !prev_stall;
                check("R2 R3 R4 R5 R6 fwd_a", fwd_a, ea);
                check("R2 R3 R4 R5 R6 fwd_b", fwd_b, eb);
                check("R7 fwd_br", fwd_br, fl[5] ? ea : 2'b00);
                check("R8 fwd_sd idle", fwd_sd, 2'b00);
                check("R9 R10 stall", {1'b0, stall}, {1'b0, es});
                prev_stall = es;
            end
        end

        // Persistent hazard pattern, R10
        @(negedge clk);
        idex_rs = 5'd3; idex_rs_used = 1'b1; idex_rt_used = 1'b0;
        exmem_rd = 5'd3; exmem_wen = 1'b1; exmem_load = 1'b1; memwb_wen = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (k > 0) @(negedge clk);
            #1;
            begin
                bit es;
                es = !prev_stall;
                check("R10 persistent stall", {1'b0, stall}, {1'b0, es});
                check("R9 no ex select from load", fwd_a, 2'b00);
                prev_stall = es;
            end
        end

        // Reset from HOLD, R11
        @(negedge clk);
        if (!prev_stall) begin
            #1;
            check("R10 stall before reset", {1'b0, stall}, 2'b01);
            @(negedge clk);
        end
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R11 stall right after reset", {1'b0, stall}, 2'b01);
        prev_stall = 1'b1;

        // Store data sweep, R8
        exmem_load = 1'b0; exmem_wen = 1'b0; idex_rs_used = 1'b0;
        for (int sr = 0; sr < 4; sr++)
        for (int wr = 0; wr < 4; wr++)
        for (int fl = 0; fl < 4; fl++) begin
            @(negedge clk);
            exmem_sd_reg = REG_W'(sr); memwb_rd = REG_W'(wr);
            memwb_wen = fl[0]; exmem_store = fl[1];
            #1;
            check("R8 fwd_sd", fwd_sd,
                  (fl[1] && fl[0] && sr != 0 && sr == wr) ? 2'b01 : 2'b00);
        end

        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule